// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked door lock that expects three code digits, entered one at a time on a value bus and qualified by a one-cycle entry strobe. The three digits are fixed by parameters. A one-hot select chooses which stored digit is compared against the bus, and a single equality comparator decides whether the entry is accepted.

If all three entries match in order, the lock opens and stays open. If any entry differs, it falls into an error state and stays there. Only a synchronous reset leaves either state. The state is encoded so that the digit select is the low three state bits and the unlock output is the top bit. No output decoding is needed.

Top module: `seq_code_lock`

## Requirements
- R1: A synchronous reset puts the lock in the first-digit state (select 3'b001, unlocked 0) on the next clock edge. This holds from any state, and reset wins over a simultaneous strobe.
- R2: The select output is one-hot: 3'b001 while waiting for the first digit, 3'b010 for the second and 3'b100 for the third. Unlocked is 0 in all three waiting states.
- R3: A strobed entry equal to the expected digit moves to the next waiting state. After the third digit is accepted, unlocked is 1 and select is 3'b000.
- R4: While strobe is low, a waiting state holds whatever value is on the bus.
- R5: A strobed entry that differs from the expected digit enters the error state (unlocked 0, select 3'b000) on the next edge.
- R6: The open state is absorbing. Unlocked stays 1 and select stays 3'b000 whatever strobes and values arrive, until reset.
- R7: The error state is absorbing. The lock never opens from it, even if the correct digits are entered afterwards, until reset.
- R8: A strobe held high for several cycles counts as one entry in each of those cycles.
- R9: Default parameters use a 4-bit bus and the digits 3, 4, 2 in entry order. After reset from the open or error state, entering 3, 4, 2 opens the lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Marks the bus value as a new digit entry |
| digit | input | DW | Entered digit value |
| unlocked | output | 1 | 1 when the door is open |
| sel | output | 3 | One-hot select of the expected stored digit |

## Verification
Assertions check on every cycle that the state stays legal with at most one hot bit. They also check that no strobe means no movement, that a strobed match shifts the state one step and a strobed mismatch lands in error, and that both terminal states hold. Only the bench's scenarios can show the complete behaviour at the ports. The bench sweeps every 4096 three-digit sequence against an arithmetic model, so it proves that exactly one sequence opens the lock. It also covers reset racing a strobe, a strobe held over several cycles, and reopening after reset.

// File: rtl/seq_code_lock.sv
module seq_code_lock #(
  parameter int DW     = 4,
  parameter int DIGIT0 = 3,
  parameter int DIGIT1 = 4,
  parameter int DIGIT2 = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] digit,
  output logic          unlocked,
  output logic [2:0]    sel
);

  localparam logic [3:0] ST_D0   = 4'b0001;
  localparam logic [3:0] ST_D1   = 4'b0010;
  localparam logic [3:0] ST_D2   = 4'b0100;
  localparam logic [3:0] ST_OPEN = 4'b1000;
  localparam logic [3:0] ST_ERR  = 4'b0000;
  localparam logic [DW-1:0] K0 = DW'(DIGIT0);
  localparam logic [DW-1:0] K1 = DW'(DIGIT1);
  localparam logic [DW-1:0] K2 = DW'(DIGIT2);

  logic [3:0]    st, st_nx;
  logic [DW-1:0] want;
  logic          match;

  assign want  = ({DW{st[0]}} & K0) | ({DW{st[1]}} & K1) | ({DW{st[2]}} & K2);
  assign match = (want == digit);

  always_comb begin
    case (st)
      ST_D0, ST_D1, ST_D2: st_nx = strobe ? (match ? {st[2:0], 1'b0} : ST_ERR) : st;
      ST_OPEN:             st_nx = ST_OPEN;
      default:             st_nx = ST_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_D0;
    else     st <= st_nx;
  end

  assign sel      = st[2:0];
  assign unlocked = st[3];

  // R1
  reset_chk: assert property (@(posedge clk) rst |=> (sel == 3'b001 && !unlocked));
  // R2
  legal_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({unlocked, sel}));
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && sel != 3'b000 && match) |=> ({unlocked, sel} == {$past(sel), 1'b0}));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe && sel != 3'b000) |=> $stable({unlocked, sel}));
  // R5
  mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && sel != 3'b000 && !match) |=> ({unlocked, sel} == 4'b0000));
  // R6
  open_chk: assert property (@(posedge clk) disable iff (rst) unlocked |=> (unlocked && sel == 3'b000));
  // R7
  err_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && sel == 3'b000) |=> (!unlocked && sel == 3'b000));

endmodule

// File: tb/test_seq_code_lock.sv
module test_seq_code_lock;
  logic       clk = 0;
  logic       rst = 1;
  logic       strobe = 0;
  logic [3:0] digit = 0;
  logic       unlocked;
  logic [2:0] sel;

  int total = 0;
  int bad = 0;
  int k = 0;
  bit done = 0;
  int code [3] = '{3, 4, 2};

  always #2 clk = ~clk;

  seq_code_lock i_seq_code_lock (
    .clk(clk), .rst(rst), .strobe(strobe), .digit(digit),
    .unlocked(unlocked), .sel(sel)
  );

  function automatic logic [2:0] exp_sel(int s);
    return (s < 3) ? 3'(1 << s) : 3'b000;
  endfunction

  task automatic check(string req);
    logic [2:0] es;
    logic eu;
    es = exp_sel(k);
    eu = (k == 3);
    total++;
    if (sel !== es || unlocked !== eu) begin
      bad++;
      $display("FAIL %s: sel=%b unlocked=%b expected sel=%b unlocked=%b", req, sel, unlocked, es, eu);
    end
  endtask

  task automatic cyc(bit r, bit s, int v);
    rst = r; strobe = s; digit = 4'(v);
    if (r) k = 0;
    else if (s && k < 3) k = (v == code[k]) ? k + 1 : 4;
    @(negedge clk);
    rst = 0; strobe = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: expired expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 0); check("R1 reset state");
    cyc(0, 0, 0); check("R2 first-digit select");
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          cyc(1, 0, 0);         check("R1 reset");
          cyc(0, 1, a);         check((a == 3) ? "R3 digit0" : "R5 digit0");
          cyc(0, 0, (a + 5) % 16); check("R4 idle");
          cyc(0, 1, b);         check((k == 4) ? "R7 error" : "R3 digit1");
          cyc(0, 1, c);         check((k == 3) ? "R3 open" : "R5 R7 closed");
          cyc(0, 1, (a + b) % 16); check((k == 3) ? "R6 open" : "R7 error");
        end
    cyc(1, 0, 0);
    for (int v = 0; v < 16; v++) begin cyc(0, 0, v); check("R4 hold sweep"); end
    cyc(0, 1, 3); check("R8 held strobe 1");
    rst = 0; strobe = 1; digit = 4; k = 2; @(negedge clk); check("R8 held strobe 2");
    digit = 2; k = 3; @(negedge clk); check("R8 held strobe 3");
    strobe = 0;
    for (int v = 0; v < 16; v++) begin cyc(0, 1, v); check("R6 open absorbs"); end
    cyc(1, 1, 7); check("R1 reset over strobe");
    cyc(0, 1, 3); cyc(0, 1, 4); cyc(0, 1, 2); check("R9 reopen after open");
    cyc(0, 1, 3); cyc(1, 0, 0); cyc(0, 1, 9); check("R5 wrong first");
    cyc(0, 1, 3); cyc(0, 1, 4); cyc(0, 1, 2); check("R7 error stays");
    cyc(1, 0, 0); cyc(0, 1, 3); cyc(0, 1, 4); cyc(0, 1, 2); check("R9 reopen after error");
    finish_run();
  end
endmodule